// File: doc/BRIEF.md
# Vector Element Load/Store Sequencer

This block moves one vector register between the vector register file and a single-port, byte-addressed memory, one element per step. A start pulse hands it a transfer (direction, addressing mode, base, stride, element count and element width), and it then walks the elements from index 0 upward. For each element it forms the memory address, drives the read or write strobe with the byte size, and either presents the store data cut from the source vector or, for loads, writes the returned data into the right slice of the destination register.

Three addressing modes share the same datapath. Packed mode steps the address by the element size. Strided mode steps it by a signed byte stride from a scalar register. Indexed mode adds one element of an offset vector to the base. A final multiplexer picks the indexed address or the running address. Element width is 1, 2 or 4 bytes, the element count is set at run time, and addresses need no alignment. While a transfer runs, the block raises `hold` so that the core's control unit waits. `hold` drops in the final state.

The controller is a Moore state machine with five states. IDLE waits for start. On start with a count of zero it goes to DONE. Otherwise it goes to LD_REQ for a load or to ST_ELEM for a store. LD_REQ always goes to LD_CAP. LD_CAP goes back to LD_REQ for the next element, or to DONE after the last one. ST_ELEM stays in ST_ELEM until the last element and then goes to DONE. DONE always returns to IDLE.

Top module: `vec_mem_seq`

## Requirements
- R1: With mode code 0 (packed), element i is accessed at base + i*B, where B is the element size in bytes.
- R2: With mode code 1 (strided), element i is accessed at base + i*stride. The stride is a 32-bit two's-complement byte count, and the sum wraps modulo 2^32.
- R3: With mode code 2 (indexed), element i is accessed at base + X. X is bits [i*8B +: 8B] of `idx_vec`, zero-extended.
- R4: A load spends two cycles on each element. The first cycle has `mem_rd` high. In the next cycle `elem_we` is high and `elem_data` holds the low 8B bits of `mem_rdata`, zero-extended. Elements follow each other with no gap.
- R5: A store spends one cycle on each element, with `mem_wr` high and `mem_wdata` equal to bits [i*8B +: 8B] of `st_vec`, zero-extended. `mem_rd` and `mem_wr` are never high together.
- R6: Width code 0, 1 and 2 select B = 1, 2 and 4 bytes; code 3 is treated as 4 bytes. `mem_size` is log2(B) for every access.
- R7: During each element write, `elem_hi` equals (i+1)*8B-1. This is the top bit of element i in the register.
- R8: `hold` is high from the cycle after an accepted start through the last element: 2*VL cycles for a load and VL cycles for a store. It is low in the following DONE cycle.
- R9: A start with VL = 0 makes no memory access and never raises `hold`.
- R10: A start that arrives while a transfer is running is ignored. Base, stride, mode, width and count are captured when the start is accepted.
- R11: After reset `hold`, `mem_rd`, `mem_wr` and `elem_we` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Transfer request, accepted in IDLE only |
| is_store | input | 1 | 1 = store vector to memory, 0 = load |
| mode | input | 2 | 0 packed, 1 strided, 2 indexed |
| sew | input | 2 | Element width code (0:1 B, 1:2 B, 2/3:4 B) |
| vl | input | VL_W | Number of elements |
| base_addr | input | AW | Byte address of the transfer |
| stride | input | AW | Signed byte stride for strided mode |
| idx_vec | input | VLEN | Offset vector for indexed mode |
| st_vec | input | VLEN | Source vector for stores |
| mem_rdata | input | 32 | Memory read data, valid the cycle after `mem_rd` |
| mem_addr | output | AW | Memory byte address |
| mem_rd | output | 1 | Memory read strobe |
| mem_wr | output | 1 | Memory write strobe |
| mem_size | output | 2 | log2 of access byte count |
| mem_wdata | output | 32 | Store data, zero-extended |
| elem_hi | output | POS_W | Top bit position of the element being written |
| elem_we | output | 1 | Register-file element write enable |
| elem_data | output | 32 | Element write data, zero-extended |
| hold | output | 1 | Stall request to the core control unit |

## Verification
The bench targets element counts and widths at their limits: 16 one-byte elements, so that `elem_hi` reaches 127, and four 4-byte elements. It also uses unaligned bases, a negative stride that moves the address downward, and indexed offsets whose slices sit above bit 31 of the offset vector. A design that used the wrong width or shift would send the wrong address or slice. A design that finished one element late would show a `hold` length different from 2*VL or VL. A design that did not latch its inputs, or that accepted a start while busy, would produce extra or corrupted scoreboard entries when a second start arrives mid-load with a different count and base. A design that gave VL = 0 any special handling incorrectly would raise `hold` or strobe memory.

// File: rtl/vms_pkg.sv
package vms_pkg;

    typedef enum logic [1:0] {
        AM_PACKED  = 2'd0,
        AM_STRIDED = 2'd1,
        AM_INDEXED = 2'd2,
        AM_RSVD    = 2'd3
    } amode_e;

    typedef enum logic [2:0] {
        SQ_IDLE   = 3'd0,
        SQ_LD_REQ = 3'd1,
        SQ_LD_CAP = 3'd2,
        SQ_ST_ELEM = 3'd3,
        SQ_DONE   = 3'd4
    } seq_state_e;

    // log2 of element byte count; reserved code 3 behaves as 4 bytes
    function automatic logic [1:0] width_lg(input logic [1:0] code);
        logic [1:0] r;
        unique case (code)
            2'd0:    r = 2'd0;
            2'd1:    r = 2'd1;
            default: r = 2'd2;
        endcase
        return r;
    endfunction

    function automatic logic [31:0] width_mask(input logic [1:0] code);
        logic [31:0] m;
        unique case (width_lg(code))
            2'd0:    m = 32'h0000_00FF;
            2'd1:    m = 32'h0000_FFFF;
            default: m = 32'hFFFF_FFFF;
        endcase
        return m;
    endfunction

endpackage

// File: rtl/vms_elem_sel.sv
module vms_elem_sel
    import vms_pkg::*;
#(
    parameter int VLEN  = 128,
    parameter int CNT_W = 5,
    parameter int POS_W = 7
) (
    input  logic [CNT_W-1:0] elem_idx,
    input  logic [1:0]       wcode,
    input  logic [VLEN-1:0]  idx_vec,
    input  logic [VLEN-1:0]  st_vec,
    input  logic [31:0]      rd_word,
    output logic [31:0]      idx_off,
    output logic [31:0]      st_word,
    output logic [31:0]      ld_word,
    output logic [POS_W-1:0] top_bit
);
    localparam int DW = 32;

    logic [4:0]    bit_sh;
    logic [31:0]   keep;
    logic [31:0]   lo_bit;
    logic [31:0]   hi_bit;
    logic [VLEN-1:0] idx_shift;
    logic [VLEN-1:0] st_shift;

    always_comb begin
        bit_sh    = 5'(width_lg(wcode)) + 5'd3;
        keep      = width_mask(wcode);
        lo_bit    = 32'(elem_idx) << bit_sh;
        hi_bit    = ((32'(elem_idx) + 32'd1) << bit_sh) - 32'd1;
        idx_shift = idx_vec >> lo_bit;
        st_shift  = st_vec >> lo_bit;
        idx_off   = idx_shift[DW-1:0] & keep;
        st_word   = st_shift[DW-1:0] & keep;
        ld_word   = rd_word & keep;
        top_bit   = POS_W'(hi_bit);
    end

endmodule

// File: rtl/vms_addr_gen.sv
module vms_addr_gen
    import vms_pkg::*;
#(
    parameter int AW = 32
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load,
    input  logic          advance,
    input  logic [1:0]    mode,
    input  logic [1:0]    wcode,
    input  logic [AW-1:0] base,
    input  logic [AW-1:0] stride,
    input  logic [31:0]   idx_off,
    output logic [AW-1:0] addr
);
    amode_e        mode_q;
    logic [AW-1:0] base_q;
    logic [AW-1:0] step_q;
    logic [AW-1:0] run_q;
    logic [AW-1:0] step_d;

    always_comb begin
        if (amode_e'(mode) == AM_STRIDED)
            step_d = stride;
        else
            step_d = AW'(32'd1 << width_lg(wcode));
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            mode_q <= AM_PACKED;
            base_q <= '0;
            step_q <= '0;
            run_q  <= '0;
        end else if (load) begin
            mode_q <= amode_e'(mode);
            base_q <= base;
            step_q <= step_d;
            run_q  <= base;
        end else if (advance) begin
            run_q  <= run_q + step_q;
        end
    end

    // address multiplexer: indexed sum or running (packed / strided) address
    always_comb begin
        if (mode_q == AM_INDEXED)
            addr = base_q + AW'(idx_off);
        else
            addr = run_q;
    end

endmodule

// File: rtl/vms_ctrl.sv
module vms_ctrl
    import vms_pkg::*;
#(
    parameter int CNT_W = 5
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic             is_store,
    input  logic [CNT_W-1:0] vl,
    input  logic [1:0]       wcode,
    output logic             accept,
    output logic             advance,
    output logic             hold,
    output logic             rd_stb,
    output logic             wr_stb,
    output logic             el_we,
    output logic [CNT_W-1:0] elem_idx,
    output logic [1:0]       wcode_q
);
    seq_state_e       state, nxt;
    logic [CNT_W-1:0] vl_q;
    logic [CNT_W-1:0] cnt_q;
    logic             store_q;
    logic             last;

    assign accept   = start && (state == SQ_IDLE);
    assign last     = (cnt_q == CNT_W'(vl_q - 1'b1));
    assign elem_idx = cnt_q;

    always_comb begin
        nxt = state;
        unique case (state)
            SQ_IDLE: begin
                if (accept) begin
                    if (vl == '0)      nxt = SQ_DONE;
                    else if (is_store) nxt = SQ_ST_ELEM;
                    else               nxt = SQ_LD_REQ;
                end
            end
            SQ_LD_REQ:  nxt = SQ_LD_CAP;
            SQ_LD_CAP:  nxt = last ? SQ_DONE : SQ_LD_REQ;
            SQ_ST_ELEM: nxt = last ? SQ_DONE : SQ_ST_ELEM;
            SQ_DONE:    nxt = SQ_IDLE;
            default:    nxt = SQ_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= SQ_IDLE;
        else        state <= nxt;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            vl_q    <= '0;
            cnt_q   <= '0;
            store_q <= 1'b0;
            wcode_q <= 2'd0;
        end else if (accept) begin
            vl_q    <= vl;
            cnt_q   <= '0;
            store_q <= is_store;
            wcode_q <= wcode;
        end else if (advance) begin
            cnt_q   <= cnt_q + 1'b1;
        end
    end

    always_comb begin
        hold    = 1'b0;
        rd_stb  = 1'b0;
        wr_stb  = 1'b0;
        el_we   = 1'b0;
        advance = 1'b0;
        unique case (state)
            SQ_IDLE:   ;
            SQ_LD_REQ: begin
                hold   = 1'b1;
                rd_stb = 1'b1;
            end
            SQ_LD_CAP: begin
                hold    = 1'b1;
                el_we   = 1'b1;
                advance = 1'b1;
            end
            SQ_ST_ELEM: begin
                hold    = 1'b1;
                wr_stb  = 1'b1;
                advance = 1'b1;
            end
            SQ_DONE:   ;
            default:   ;
        endcase
    end

    AST_READ_THEN_CAPTURE: assert property (@(posedge clk) disable iff (!rst_n)
        rd_stb |=> (el_we && !rd_stb)); // R4

    AST_NO_RD_WR_OVERLAP: assert property (@(posedge clk) disable iff (!rst_n)
        rd_stb |-> !wr_stb); // R5

    AST_STROBE_UNDER_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_stb || wr_stb || el_we) |-> hold); // R8

    AST_EMPTY_NO_ACCESS: assert property (@(posedge clk) disable iff (!rst_n)
        (accept && vl == '0) |=> (!hold && !rd_stb && !wr_stb)); // R9

    AST_BUSY_START_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
        (start && hold) |=> ($stable(vl_q) && $stable(store_q) && $stable(wcode_q))); // R10

    AST_COUNT_BELOW_VL: assert property (@(posedge clk) disable iff (!rst_n)
        hold |-> (cnt_q < vl_q)); // R1

endmodule

// File: rtl/vec_mem_seq.sv
module vec_mem_seq
    import vms_pkg::*;
#(
    parameter int VLEN = 128,
    parameter int AW   = 32,
    localparam int VL_W  = $clog2(VLEN / 8) + 1,
    localparam int POS_W = $clog2(VLEN)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic             is_store,
    input  logic [1:0]       mode,
    input  logic [1:0]       sew,
    input  logic [VL_W-1:0]  vl,
    input  logic [AW-1:0]    base_addr,
    input  logic [AW-1:0]    stride,
    input  logic [VLEN-1:0]  idx_vec,
    input  logic [VLEN-1:0]  st_vec,
    input  logic [31:0]      mem_rdata,
    output logic [AW-1:0]    mem_addr,
    output logic             mem_rd,
    output logic             mem_wr,
    output logic [1:0]       mem_size,
    output logic [31:0]      mem_wdata,
    output logic [POS_W-1:0] elem_hi,
    output logic             elem_we,
    output logic [31:0]      elem_data,
    output logic             hold
);
    logic            accept;
    logic            advance;
    logic [VL_W-1:0] elem_idx;
    logic [1:0]      wcode_q;
    logic [31:0]     idx_off;

    vms_ctrl #(.CNT_W(VL_W)) u_ctrl (
        .clk      (clk),
        .rst_n    (rst_n),
        .start    (start),
        .is_store (is_store),
        .vl       (vl),
        .wcode    (sew),
        .accept   (accept),
        .advance  (advance),
        .hold     (hold),
        .rd_stb   (mem_rd),
        .wr_stb   (mem_wr),
        .el_we    (elem_we),
        .elem_idx (elem_idx),
        .wcode_q  (wcode_q)
    );

    vms_elem_sel #(.VLEN(VLEN), .CNT_W(VL_W), .POS_W(POS_W)) u_sel (
        .elem_idx (elem_idx),
        .wcode    (wcode_q),
        .idx_vec  (idx_vec),
        .st_vec   (st_vec),
        .rd_word  (mem_rdata),
        .idx_off  (idx_off),
        .st_word  (mem_wdata),
        .ld_word  (elem_data),
        .top_bit  (elem_hi)
    );

    vms_addr_gen #(.AW(AW)) u_addr (
        .clk     (clk),
        .rst_n   (rst_n),
        .load    (accept),
        .advance (advance),
        .mode    (mode),
        .wcode   (sew),
        .base    (base_addr),
        .stride  (stride),
        .idx_off (idx_off),
        .addr    (mem_addr)
    );

    assign mem_size = width_lg(wcode_q);

    AST_SIZE_STEADY: assert property (@(posedge clk) disable iff (!rst_n)
        (hold && $past(hold)) |-> $stable(mem_size)); // R6

endmodule

// File: tb/vec_mem_seq_tb.sv
module vec_mem_seq_tb;
    localparam int VLEN  = 128;
    localparam int AW    = 32;
    localparam int VL_W  = $clog2(VLEN / 8) + 1;
    localparam int POS_W = $clog2(VLEN);

    typedef struct {
        int          kind;   // 0 read, 1 element write, 2 memory write
        logic [31:0] addr;
        logic [31:0] data;
        logic [1:0]  size;
        int          hi;
        string       tag;
    } ev_t;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             start = 1'b0;
    logic             is_store = 1'b0;
    logic [1:0]       mode = 2'd0;
    logic [1:0]       sew = 2'd0;
    logic [VL_W-1:0]  vl = '0;
    logic [AW-1:0]    base_addr = '0;
    logic [AW-1:0]    stride = '0;
    logic [VLEN-1:0]  idx_vec = '0;
    logic [VLEN-1:0]  st_vec = '0;
    logic [31:0]      mem_rdata = '0;
    logic [AW-1:0]    mem_addr;
    logic             mem_rd, mem_wr, elem_we, hold;
    logic [1:0]       mem_size;
    logic [31:0]      mem_wdata, elem_data;
    logic [POS_W-1:0] elem_hi;

    logic [7:0] mem [256];
    ev_t sb[$];
    int  n_chk = 0;
    int  n_bad = 0;
    bit  finished = 1'b0;

    always #2 clk = ~clk;

    vec_mem_seq #(.VLEN(VLEN), .AW(AW)) u_dut (
        .clk(clk), .rst_n(rst_n), .start(start), .is_store(is_store),
        .mode(mode), .sew(sew), .vl(vl), .base_addr(base_addr),
        .stride(stride), .idx_vec(idx_vec), .st_vec(st_vec),
        .mem_rdata(mem_rdata), .mem_addr(mem_addr), .mem_rd(mem_rd),
        .mem_wr(mem_wr), .mem_size(mem_size), .mem_wdata(mem_wdata),
        .elem_hi(elem_hi), .elem_we(elem_we), .elem_data(elem_data),
        .hold(hold)
    );

    function automatic logic [31:0] mem_word(input logic [31:0] a);
        return {mem[8'(a + 3)], mem[8'(a + 2)], mem[8'(a + 1)], mem[8'(a)]};
    endfunction

    // memory model: read data appears the cycle after the strobe
    always @(posedge clk) if (mem_rd) mem_rdata <= mem_word(mem_addr);

    task automatic chk(input bit ok, input string tag, input logic [31:0] act,
                       input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // monitor: pop one expected item per strobe and compare
    always @(negedge clk) begin
        if (rst_n && (mem_rd || mem_wr || elem_we)) begin
            int k;
            k = mem_rd ? 0 : (elem_we ? 1 : 2);
            if (sb.size() == 0) begin
                chk(1'b0, "unexpected strobe", 32'(k), 32'hFFFF_FFFF);
            end else begin
                ev_t e;
                e = sb.pop_front();
                chk(k == e.kind, {e.tag, " kind"}, 32'(k), 32'(e.kind));
                if (k == 1) begin
                    chk(int'(elem_hi) == e.hi, {e.tag, " elem_hi R7"}, 32'(elem_hi), 32'(e.hi));
                    chk(elem_data == e.data, {e.tag, " elem_data R4"}, elem_data, e.data);
                end else begin
                    chk(mem_addr == e.addr, {e.tag, " addr"}, mem_addr, e.addr);
                    chk(mem_size == e.size, {e.tag, " size R6"}, 32'(mem_size), 32'(e.size));
                    if (k == 2)
                        chk(mem_wdata == e.data, {e.tag, " wdata R5"}, mem_wdata, e.data);
                end
            end
        end
    end

    task automatic run_op(input bit st, input logic [1:0] md, input logic [1:0] w,
                          input int n, input logic [31:0] b, input logic [31:0] s,
                          input bit poke, input string tag);
        int bytes, bits, hc, exp_hold;
        logic [31:0] msk, a, off;
        bytes = (w == 2'd0) ? 1 : (w == 2'd1) ? 2 : 4;
        bits  = bytes * 8;
        msk   = (bytes == 4) ? 32'hFFFF_FFFF : ((32'd1 << bits) - 32'd1);
        for (int i = 0; i < n; i++) begin
            ev_t e;
            off = 32'(idx_vec >> (i * bits)) & msk;
            if (md == 2'd0)      a = b + 32'(i * bytes);
            else if (md == 2'd1) a = b + 32'(i) * s;
            else                 a = b + off;
            e.addr = a; e.size = 2'($clog2(bytes)); e.hi = (i + 1) * bits - 1;
            e.tag = tag;
            if (st) begin
                e.kind = 2; e.data = 32'(st_vec >> (i * bits)) & msk;
                sb.push_back(e);
            end else begin
                e.kind = 0; e.data = '0;
                sb.push_back(e);
                e.kind = 1; e.data = mem_word(a) & msk;
                sb.push_back(e);
            end
        end
        @(negedge clk);
        is_store = st; mode = md; sew = w; vl = VL_W'(n);
        base_addr = b; stride = s; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        hc = 0;
        while (hold) begin
            hc++;
            if (poke && hc == 3) begin
                start = 1'b1; vl = VL_W'(2); base_addr = 32'hDEAD_0000;
                mode = 2'd1; is_store = ~st;
            end else begin
                start = 1'b0;
            end
            @(negedge clk);
        end
        start = 1'b0;
        exp_hold = st ? n : 2 * n;
        chk(hc == exp_hold, {tag, " hold length R8"}, 32'(hc), 32'(exp_hold));
        chk(sb.size() == 0, {tag, " all items seen"}, 32'(sb.size()), 32'd0);
        repeat (2) @(negedge clk);
        chk(!hold, {tag, " back to idle R8"}, 32'(hold), 32'd0);
    endtask

    initial begin
        for (int i = 0; i < 256; i++) mem[i] = 8'(i * 7 + 3);
        repeat (3) @(negedge clk);
        chk(!hold && !mem_rd && !mem_wr && !elem_we, "R11 reset outputs",
            {28'd0, hold, mem_rd, mem_wr, elem_we}, 32'd0);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 R4 R7: packed load, 16 bytes, top bit 127
        run_op(1'b0, 2'd0, 2'd0, 16, 32'h0000_0010, 32'd0, 1'b0, "R1 packed load e8");
        // R1 R6: packed load, halfwords, unaligned base
        run_op(1'b0, 2'd0, 2'd1, 5, 32'h0000_0021, 32'd0, 1'b0, "R1 packed load e16 unaligned");
        // R2: strided load, words
        run_op(1'b0, 2'd1, 2'd2, 4, 32'h0000_0003, 32'd7, 1'b0, "R2 strided load e32");
        // R3: indexed load, halfword offsets
        for (int i = 0; i < 8; i++) idx_vec[i*16 +: 16] = 16'(i * 13 + 1);
        run_op(1'b0, 2'd2, 2'd1, 8, 32'h0000_0040, 32'd0, 1'b0, "R3 indexed load e16");
        // R5: packed store, words
        for (int i = 0; i < 4; i++) st_vec[i*32 +: 32] = 32'hA5C3_0000 + 32'(i * 32'h1111);
        run_op(1'b1, 2'd0, 2'd2, 4, 32'h0000_1002, 32'd0, 1'b0, "R5 packed store e32");
        // R2 R5: strided store with negative stride
        for (int i = 0; i < 16; i++) st_vec[i*8 +: 8] = 8'(200 - i * 9);
        run_op(1'b1, 2'd1, 2'd0, 10, 32'h0000_0080, 32'hFFFF_FFFD, 1'b0, "R2 strided store neg");
        // R3 R5: indexed store, byte offsets
        for (int i = 0; i < 16; i++) idx_vec[i*8 +: 8] = 8'(i * 5 + 2);
        run_op(1'b1, 2'd2, 2'd0, 16, 32'h0000_0100, 32'd0, 1'b0, "R3 indexed store e8");
        // R6: reserved width code acts as 4 bytes
        run_op(1'b0, 2'd0, 2'd3, 2, 32'h0000_0055, 32'd0, 1'b0, "R6 reserved width");
        // R9: empty transfer
        run_op(1'b0, 2'd0, 2'd0, 0, 32'h0000_0000, 32'd0, 1'b0, "R9 zero length");
        run_op(1'b1, 2'd1, 2'd1, 0, 32'h0000_0000, 32'd4, 1'b0, "R9 zero length store");
        // R10: second start mid-transfer with different settings
        run_op(1'b0, 2'd0, 2'd1, 6, 32'h0000_0030, 32'd0, 1'b1, "R10 busy start load");
        run_op(1'b1, 2'd0, 2'd0, 9, 32'h0000_0200, 32'd0, 1'b1, "R10 busy start store");

        finished = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
            $finish;
        end
    end

endmodule